// File: doc/BRIEF.md
# Virtio common configuration register file

This block is the device-side register file behind the common configuration structure of a virtio PCI function. A host register port with 32-bit data, byte lanes and a byte address lets the driver read the offered feature bits, write back the subset it accepts, drive device status, program the configuration interrupt vector and set up each virtqueue. The per-queue registers are banked behind a queue selector.

The device core sees the results as plain outputs: the 64 accepted feature bits, device status, the configuration vector, and for every queue its size, enable, interrupt vector and the three ring base addresses. Reads return one cycle after the request. All multi-byte fields are little-endian dwords at the word offsets below, and a field changes only when it is written with its natural width.

Word map (byte offset: contents): 0x00 device feature select; 0x04 device feature window (read-only); 0x08 driver feature select; 0x0C driver feature window; 0x10 config vector [15:0], queue count [31:16] (read-only); 0x14 device status [7:0], queue select [31:16]; 0x18 queue size [15:0], queue vector [31:16]; 0x1C queue enable [15:0], notify offset [31:16] (read-only); 0x20/0x24 descriptor table address low/high; 0x28/0x2C available ring low/high; 0x30/0x34 used ring low/high. Other offsets read zero and ignore writes.

Top module: `vqc_regs`

## Requirements
- R1: After reset, device status, feature selects, queue select and accepted features are 0, every queue size reads the maximum (default 256), every vector (config and queue) reads 0xFFFF and every queue is disabled.
- R2: The device feature window at 0x04 shows offered bits 31:0 when its select is 0 and bits 63:32 when the select is 1, with bit 32 (window bit 0) always set; any other select reads 0.
- R3: A driver feature select of 0 or 1 maps 0x0C onto accepted bits 31:0 or 63:32; with any other select, writes to 0x0C leave the accepted features unchanged and reads return 0.
- R4: Queue size, vector, enable, notify offset and ring addresses refer to the queue named by the queue select; a select at or above the queue count (default 4) reads 0 for all of them and ignores writes.
- R5: A queue size write is taken only if the value is 0 or a power of two not above the maximum; other values are ignored.
- R6: A vector write (config or queue) below the table size (default 32) stores the value; any other value stores 0xFFFF, which is read back.
- R7: The queue count and notify offset (equal to the queue index) are read-only; writes to them change nothing.
- R8: A 16-bit field is written only when both of its byte lanes are enabled, status only with lane 0, and 32-bit registers only with all four lanes; offsets not aligned to a dword are ignored.
- R9: Writing 0 to device status returns every queue's size, vector, enable and ring addresses and the accepted features to their reset values.
- R10: Each 64-bit ring address is written and read as a low dword followed by a high dword and appears whole on the queue's output.
- R11: A read request returns its data with rd_valid exactly one cycle later; rd_valid is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW (8) | Byte address |
| wdata | input | 32 | Write data, little-endian |
| be | input | 4 | Byte lane enables |
| rdata | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid |
| drv_features | output | 64 | Features accepted by the driver |
| dev_status | output | 8 | Device status byte |
| cfg_vector | output | 16 | Configuration change vector |
| q_size | output | NQ*16 | Per-queue size, queue i at [16i+15:16i] |
| q_vector | output | NQ*16 | Per-queue interrupt vector |
| q_enable | output | NQ | Per-queue enable |
| q_desc | output | NQ*64 | Per-queue descriptor table address |
| q_avail | output | NQ*64 | Per-queue available ring address |
| q_used | output | NQ*64 | Per-queue used ring address |

## Verification
On every cycle the assertions hold the legal value sets: each queue size is zero or a power of two within the maximum, every vector is inside the table or 0xFFFF, a status write of zero leaves no accepted feature and no enabled queue, out-of-range driver selects freeze the accepted features, and reads answer after exactly one cycle. Only the bench scenarios can show the window and bank mapping itself: which half of the features a select exposes, that a selector steers writes to one queue and leaves the others, that partial-lane writes and read-only fields are ignored, and that the 64-bit addresses assemble from the right dwords.

// File: rtl/vqc_pkg.sv
package vqc_pkg;
   // dword indices of the common configuration words
   localparam int W_DSEL     = 0;
   localparam int W_DFEAT    = 1;
   localparam int W_GSEL     = 2;
   localparam int W_GFEAT    = 3;
   localparam int W_VEC      = 4;
   localparam int W_STAT     = 5;
   localparam int W_QSZ      = 6;
   localparam int W_QEN      = 7;
   localparam int W_RING0    = 8;
   localparam int NWORDS     = 14;
   localparam logic [15:0] NO_VEC = 16'hFFFF;

   function automatic logic size_legal(input logic [15:0] v, input int unsigned lim);
      return (v == 16'd0) || (((v & (v - 16'd1)) == 16'd0) && (32'(v) <= lim));
   endfunction

   function automatic logic [15:0] vec_filter(input logic [15:0] v, input int unsigned tbl);
      return (32'(v) < tbl) ? v : NO_VEC;
   endfunction
endpackage

// File: rtl/vqc_feat.sv
module vqc_feat #(
   parameter logic [63:0] DEV_FEAT = 64'h0000_0002_0000_0021
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        we_dsel,
   input  logic        we_gsel,
   input  logic        we_gfeat,
   input  logic [31:0] wdata,
   output logic [31:0] dsel,
   output logic [31:0] gsel,
   output logic [31:0] dev_rd,
   output logic [31:0] drv_rd,
   output logic [63:0] drv_features
);
   localparam logic [63:0] OFFERED = DEV_FEAT | (64'd1 << 32);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dsel <= '0;
         gsel <= '0;
         drv_features <= '0;
      end else begin
         if (we_dsel) dsel <= wdata;
         if (we_gsel) gsel <= wdata;
         if (clr) begin
            drv_features <= '0;
         end else if (we_gfeat) begin
            if (gsel == 32'd0)      drv_features[31:0]  <= wdata;
            else if (gsel == 32'd1) drv_features[63:32] <= wdata;
         end
      end
   end

   always_comb begin
      dev_rd = (dsel == 32'd0) ? OFFERED[31:0] :
               (dsel == 32'd1) ? OFFERED[63:32] : 32'd0;
      drv_rd = (gsel == 32'd0) ? drv_features[31:0] :
               (gsel == 32'd1) ? drv_features[63:32] : 32'd0;
   end
endmodule

// File: rtl/vqc_queue_bank.sv
module vqc_queue_bank
   import vqc_pkg::*;
#(
   parameter int NQ   = 4,
   parameter int QMAX = 256,
   parameter int MSIX = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [15:0]      qsel,
   input  logic             we_size,
   input  logic             we_vec,
   input  logic             we_en,
   input  logic [5:0]       we_ring,
   input  logic [31:0]      wdata,
   output logic [15:0]      rd_size,
   output logic [15:0]      rd_vec,
   output logic [15:0]      rd_en,
   output logic [15:0]      rd_notify,
   output logic [63:0]      rd_desc,
   output logic [63:0]      rd_avail,
   output logic [63:0]      rd_used,
   output logic [NQ*16-1:0] q_size,
   output logic [NQ*16-1:0] q_vector,
   output logic [NQ-1:0]    q_enable,
   output logic [NQ*64-1:0] q_desc,
   output logic [NQ*64-1:0] q_avail,
   output logic [NQ*64-1:0] q_used
);
   localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;

   logic          sel_ok;
   logic [QW-1:0] qi;

   assign sel_ok = 32'(qsel) < NQ;
   assign qi     = qsel[QW-1:0];

   for (genvar i = 0; i < NQ; i++) begin : g_q
      logic            hit;
      logic [15:0]     size_r;
      logic [15:0]     vec_r;
      logic            en_r;
      logic [2:0][63:0] ring_r;

      assign hit = sel_ok && (qi == QW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            size_r <= 16'(QMAX);
            vec_r  <= NO_VEC;
            en_r   <= 1'b0;
            ring_r <= '0;
         end else if (clr) begin
            size_r <= 16'(QMAX);
            vec_r  <= NO_VEC;
            en_r   <= 1'b0;
            ring_r <= '0;
         end else if (hit) begin
            if (we_size && size_legal(wdata[15:0], QMAX)) size_r <= wdata[15:0];
            if (we_vec) vec_r <= vec_filter(wdata[31:16], MSIX);
            if (we_en)  en_r  <= wdata[0];
            for (int r = 0; r < 6; r++) begin
               if (we_ring[r]) ring_r[r/2][32*(r%2) +: 32] <= wdata;
            end
         end
      end

      assign q_size[i*16 +: 16]   = size_r;
      assign q_vector[i*16 +: 16] = vec_r;
      assign q_enable[i]          = en_r;
      assign q_desc[i*64 +: 64]   = ring_r[0];
      assign q_avail[i*64 +: 64]  = ring_r[1];
      assign q_used[i*64 +: 64]   = ring_r[2];
   end

   always_comb begin
      rd_size = '0; rd_vec = '0; rd_en = '0; rd_notify = '0;
      rd_desc = '0; rd_avail = '0; rd_used = '0;
      if (sel_ok) begin
         rd_size   = q_size[qi*16 +: 16];
         rd_vec    = q_vector[qi*16 +: 16];
         rd_en     = {15'd0, q_enable[qi]};
         rd_notify = qsel;
         rd_desc   = q_desc[qi*64 +: 64];
         rd_avail  = q_avail[qi*64 +: 64];
         rd_used   = q_used[qi*64 +: 64];
      end
   end
endmodule

// File: rtl/vqc_regs.sv
module vqc_regs
   import vqc_pkg::*;
#(
   parameter int          NQ       = 4,
   parameter int          QMAX     = 256,
   parameter int          MSIX     = 32,
   parameter logic [63:0] DEV_FEAT = 64'h0000_0002_0000_0021,
   parameter int          AW       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [AW-1:0]    addr,
   input  logic [31:0]      wdata,
   input  logic [3:0]       be,
   output logic [31:0]      rdata,
   output logic             rd_valid,
   output logic [63:0]      drv_features,
   output logic [7:0]       dev_status,
   output logic [15:0]      cfg_vector,
   output logic [NQ*16-1:0] q_size,
   output logic [NQ*16-1:0] q_vector,
   output logic [NQ-1:0]    q_enable,
   output logic [NQ*64-1:0] q_desc,
   output logic [NQ*64-1:0] q_avail,
   output logic [NQ*64-1:0] q_used
);
   localparam int WW = AW - 2;

   if (NQ < 1 || NQ > 65535) begin : g_bad_nq
      $error("vqc_regs: NQ out of range");
   end
   if (QMAX < 1 || QMAX > 32768 || (QMAX & (QMAX - 1)) != 0) begin : g_bad_qmax
      $error("vqc_regs: QMAX must be a power of two up to 32768");
   end
   if (MSIX < 1 || MSIX > 2048) begin : g_bad_msix
      $error("vqc_regs: MSIX must be 1..2048");
   end
   if (AW < 6) begin : g_bad_aw
      $error("vqc_regs: AW too small for the word map");
   end

   logic [WW-1:0]     widx;
   logic              aligned, lo16, hi16, full, clr;
   logic [NWORDS-1:0] hitv, ws;
   logic [15:0]       qsel;
   logic [31:0]       dsel_w, gsel_w, dev_rd, drv_rd, rmux;
   logic [15:0]       b_size, b_vec, b_en, b_notify;
   logic [63:0]       b_desc, b_avail, b_used;

   assign widx    = addr[AW-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign lo16    = (be[1:0] == 2'b11);
   assign hi16    = (be[3:2] == 2'b11);
   assign full    = (be == 4'hF);

   for (genvar n = 0; n < NWORDS; n++) begin : g_dec
      assign hitv[n] = aligned && (widx == WW'(n));
      assign ws[n]   = wr_en && hitv[n];
   end

   assign clr = ws[W_STAT] && be[0] && (wdata[7:0] == 8'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_status <= '0;
         qsel       <= '0;
         cfg_vector <= NO_VEC;
      end else begin
         if (ws[W_STAT] && be[0]) dev_status <= wdata[7:0];
         if (ws[W_STAT] && hi16)  qsel       <= wdata[31:16];
         if (ws[W_VEC] && lo16)   cfg_vector <= vec_filter(wdata[15:0], MSIX);
      end
   end

   vqc_feat #(.DEV_FEAT(DEV_FEAT)) u_feat (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr          (clr),
      .we_dsel      (ws[W_DSEL] && full),
      .we_gsel      (ws[W_GSEL] && full),
      .we_gfeat     (ws[W_GFEAT] && full),
      .wdata        (wdata),
      .dsel         (dsel_w),
      .gsel         (gsel_w),
      .dev_rd       (dev_rd),
      .drv_rd       (drv_rd),
      .drv_features (drv_features)
   );

   vqc_queue_bank #(.NQ(NQ), .QMAX(QMAX), .MSIX(MSIX)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .qsel      (qsel),
      .we_size   (ws[W_QSZ] && lo16),
      .we_vec    (ws[W_QSZ] && hi16),
      .we_en     (ws[W_QEN] && lo16),
      .we_ring   (ws[W_RING0 +: 6] & {6{full}}),
      .wdata     (wdata),
      .rd_size   (b_size),
      .rd_vec    (b_vec),
      .rd_en     (b_en),
      .rd_notify (b_notify),
      .rd_desc   (b_desc),
      .rd_avail  (b_avail),
      .rd_used   (b_used),
      .q_size    (q_size),
      .q_vector  (q_vector),
      .q_enable  (q_enable),
      .q_desc    (q_desc),
      .q_avail   (q_avail),
      .q_used    (q_used)
   );

   always_comb begin
      rmux = '0;
      if (hitv[W_DSEL])       rmux = dsel_w;
      if (hitv[W_DFEAT])      rmux = dev_rd;
      if (hitv[W_GSEL])       rmux = gsel_w;
      if (hitv[W_GFEAT])      rmux = drv_rd;
      if (hitv[W_VEC])        rmux = {16'(NQ), cfg_vector};
      if (hitv[W_STAT])       rmux = {qsel, 8'd0, dev_status};
      if (hitv[W_QSZ])        rmux = {b_vec, b_size};
      if (hitv[W_QEN])        rmux = {b_notify, b_en};
      if (hitv[W_RING0])      rmux = b_desc[31:0];
      if (hitv[W_RING0 + 1])  rmux = b_desc[63:32];
      if (hitv[W_RING0 + 2])  rmux = b_avail[31:0];
      if (hitv[W_RING0 + 3])  rmux = b_avail[63:32];
      if (hitv[W_RING0 + 4])  rmux = b_used[31:0];
      if (hitv[W_RING0 + 5])  rmux = b_used[63:32];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rdata <= rmux;
      end
   end
endmodule

// File: rtl/vqc_regs_chk.sv
module vqc_regs_chk #(
   parameter int NQ   = 4,
   parameter int QMAX = 256,
   parameter int MSIX = 32,
   parameter int AW   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [AW-1:0]    addr,
   input logic [31:0]      wdata,
   input logic [3:0]       be,
   input logic             rd_valid,
   input logic [63:0]      drv_features,
   input logic [15:0]      cfg_vector,
   input logic [NQ*16-1:0] q_size,
   input logic [NQ*16-1:0] q_vector,
   input logic [NQ-1:0]    q_enable,
   input logic [31:0]      gsel
);
   for (genvar i = 0; i < NQ; i++) begin : g_c
      // R5
      size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($countones(q_size[i*16 +: 16]) <= 1) && (32'(q_size[i*16 +: 16]) <= QMAX));
      // R6
      qvec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (32'(q_vector[i*16 +: 16]) < MSIX) || (q_vector[i*16 +: 16] == 16'hFFFF));
   end

   // R6
   cfgvec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(cfg_vector) < MSIX) || (cfg_vector == 16'hFFFF));

   // R9
   status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(8'h14) && be[0] && wdata[7:0] == 8'd0)
      |=> (drv_features == 64'd0) && (q_enable == '0));

   // R3
   drv_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(8'h0C) && gsel > 32'd1) |=> $stable(drv_features));

   // R11
   rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   // R11
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
endmodule

bind vqc_regs vqc_regs_chk #(.NQ(NQ), .QMAX(QMAX), .MSIX(MSIX), .AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .addr         (addr),
   .wdata        (wdata),
   .be           (be),
   .rd_valid     (rd_valid),
   .drv_features (drv_features),
   .cfg_vector   (cfg_vector),
   .q_size       (q_size),
   .q_vector     (q_vector),
   .q_enable     (q_enable),
   .gsel         (gsel_w)
);

// File: tb/vqc_regs_bench.sv
module vqc_regs_bench;
   localparam int CLK_P = 10;
   localparam int NQ = 4;

   localparam logic [7:0] A_DSEL = 8'h00, A_DFEAT = 8'h04, A_GSEL = 8'h08, A_GFEAT = 8'h0C;
   localparam logic [7:0] A_VEC = 8'h10, A_STAT = 8'h14, A_QSZ = 8'h18, A_QEN = 8'h1C;
   localparam logic [7:0] A_DESC = 8'h20, A_USED = 8'h30;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [3:0] be = '0;
   logic [31:0] rdata;
   logic rd_valid;
   logic [63:0] drv_features;
   logic [7:0] dev_status;
   logic [15:0] cfg_vector;
   logic [NQ*16-1:0] q_size, q_vector;
   logic [NQ-1:0] q_enable;
   logic [NQ*64-1:0] q_desc, q_avail, q_used;

   int total = 0, bad = 0;
   logic done = 1'b0;
   logic [31:0] exp_q[$];
   string tag_q[$];

   always #(CLK_P/2) clk = ~clk;

   vqc_regs u_vqc_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .be(be), .rdata(rdata), .rd_valid(rd_valid),
      .drv_features(drv_features), .dev_status(dev_status), .cfg_vector(cfg_vector),
      .q_size(q_size), .q_vector(q_vector), .q_enable(q_enable),
      .q_desc(q_desc), .q_avail(q_avail), .q_used(q_used)
   );

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d; be = b;
      @(negedge clk);
      wr_en = 1'b0; be = '0;
   endtask

   // driver: queue the expected word, then issue the read
   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // monitor: compare returned words against the scoreboard
   always @(negedge clk) begin
      if (rst_n && rd_valid && !done) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R11 unexpected rd_valid actual=%h expected=none", rdata);
         end else begin
            chk({32'd0, rdata}, {32'd0, exp_q.pop_front()}, tag_q.pop_front());
         end
      end
   end

   initial begin
      #(CLK_P * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_QSZ, {16'hFFFF, 16'd256}, "R1 queue0 size/vector");
      rd(A_STAT, 32'd0, "R1 status/select");
      rd(A_VEC, {16'd4, 16'hFFFF}, "R1 config vector/queue count");
      chk({60'd0, q_enable}, 64'd0, "R1 enables");
      chk(drv_features, 64'd0, "R1 accepted features");
      chk({48'd0, q_vector[63:48]}, 64'hFFFF, "R1 queue3 vector");

      // R2 device feature windows
      rd(A_DFEAT, 32'h0000_0021, "R2 window 0");
      wr(A_DSEL, 32'd1, 4'hF);
      rd(A_DFEAT, 32'h0000_0003, "R2 window 1 with bit 32");
      wr(A_DSEL, 32'd7, 4'hF);
      rd(A_DFEAT, 32'd0, "R2 out-of-range window");

      // R3 driver feature windows
      wr(A_GFEAT, 32'hAAAA_5555, 4'hF);
      wr(A_GSEL, 32'd1, 4'hF);
      wr(A_GFEAT, 32'h0000_0001, 4'hF);
      chk(drv_features, 64'h0000_0001_AAAA_5555, "R3 accepted both halves");
      rd(A_GFEAT, 32'd1, "R3 high half read");
      wr(A_GSEL, 32'd2, 4'hF);
      wr(A_GFEAT, 32'hFFFF_FFFF, 4'hF);
      chk(drv_features, 64'h0000_0001_AAAA_5555, "R3 ignored write");
      rd(A_GFEAT, 32'd0, "R3 out-of-range read");

      // R6 config vector validation, R8 partial lanes
      wr(A_VEC, 32'd5, 4'b0011);
      rd(A_VEC, {16'd4, 16'd5}, "R6 valid config vector");
      wr(A_VEC, 32'd32, 4'b0011);
      chk({48'd0, cfg_vector}, 64'hFFFF, "R6 config vector out of table");
      wr(A_VEC, 32'd7, 4'b0001);
      chk({48'd0, cfg_vector}, 64'hFFFF, "R8 half-lane vector write ignored");
      // R7 queue count read-only
      wr(A_VEC, 32'h0009_0000, 4'b1100);
      rd(A_VEC, {16'd4, 16'hFFFF}, "R7 queue count read-only");
      // R8 misaligned
      wr(A_QSZ + 8'd1, 32'd64, 4'hF);
      chk({48'd0, q_size[15:0]}, 64'd256, "R8 misaligned write ignored");

      // R4 bank select, R5 size, R6 queue vector
      wr(A_STAT, {16'd2, 16'd0}, 4'b1100);
      wr(A_QSZ, {16'd3, 16'd64}, 4'hF);
      chk({48'd0, q_size[47:32]}, 64'd64, "R4 queue2 size");
      chk({48'd0, q_vector[47:32]}, 64'd3, "R4 queue2 vector");
      chk({48'd0, q_size[15:0]}, 64'd256, "R4 queue0 untouched");
      wr(A_QSZ, 32'd100, 4'b0011);
      chk({48'd0, q_size[47:32]}, 64'd64, "R5 non-power size ignored");
      wr(A_QSZ, 32'd512, 4'b0011);
      chk({48'd0, q_size[47:32]}, 64'd64, "R5 oversize ignored");
      wr(A_QSZ, {16'd40, 16'd0}, 4'hF);
      rd(A_QSZ, {16'hFFFF, 16'd0}, "R5 size 0 and R6 vector fail");

      // R7 notify offset, enable
      rd(A_QEN, {16'd2, 16'd0}, "R7 notify offset");
      wr(A_QEN, {16'd7, 16'd1}, 4'hF);
      rd(A_QEN, {16'd2, 16'd1}, "R7 notify read-only");
      chk({60'd0, q_enable}, 64'h4, "R4 only queue2 enabled");

      // R10 ring addresses
      wr(A_DESC, 32'h0000_1000, 4'hF);
      wr(A_DESC + 8'd4, 32'h0000_0002, 4'hF);
      chk(q_desc[191:128], 64'h0000_0002_0000_1000, "R10 descriptor address");
      wr(A_USED + 8'd4, 32'hDEAD_0001, 4'hF);
      rd(A_USED + 8'd4, 32'hDEAD_0001, "R10 used high dword");
      chk(q_used[191:128], 64'hDEAD_0001_0000_0000, "R10 used address");

      // R4 out-of-range selector
      wr(A_STAT, {16'd9, 16'd0}, 4'b1100);
      rd(A_QSZ, 32'd0, "R4 out-of-range read");
      wr(A_QSZ, 32'd16, 4'b0011);
      chk({q_size[63:48], q_size[47:32], q_size[31:16], q_size[15:0]},
          {16'd256, 16'd0, 16'd256, 16'd256}, "R4 out-of-range write ignored");

      // R9 status reset
      wr(A_STAT, {16'd2, 16'h000F}, 4'hF);
      rd(A_STAT, {16'd2, 16'h000F}, "R9 status value");
      wr(A_STAT, {16'd2, 16'h0000}, 4'b0001);
      chk(drv_features, 64'd0, "R9 features cleared");
      chk({60'd0, q_enable}, 64'd0, "R9 enables cleared");
      chk({48'd0, q_size[47:32]}, 64'd256, "R9 size restored");
      chk(q_desc[191:128], 64'd0, "R9 ring cleared");

      // R11 idle
      @(negedge clk);
      chk({63'd0, rd_valid}, 64'd0, "R11 idle rd_valid");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL R11 missing read data actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule